// File: doc/BRIEF.md
# Character Overlay Raster Timing Generator

This block produces the scan-position information that a text overlay engine needs to place a grid of glyph cells on a video frame. It counts display-clock periods from each horizontal-sync rising edge and sync pulses from each vertical-sync rising edge. It places the character window at programmable horizontal and vertical offsets. While the window is being scanned it reports which display-memory cell is under the beam and which dot column and dot row of a 12-wide by 18-tall glyph are being drawn.

A single mode bit selects a grid of 24 cells by 10 text lines or 32 cells by 7 text lines. Dots can be stretched horizontally by 1 to 4 clocks and vertically by 1 to 4 scan lines. The top text line has its own pair of stretch settings. An optional one-text-line blank gap can be placed below text lines 2 and 8. A cursor flag marks one underline dot row of one chosen cell. Glyph lookup, colouring and video encoding take these outputs downstream.

Top module: `char_raster_timer`

## Requirements
- R1: Inside the window, `dot_col` runs 0 to 11 across each cell and `dot_row` runs 0 to 17 down each text line, each step lasting the selected number of clocks or scan lines.
- R2: `mode32`=0 gives 24 cells by 10 lines and `mode32`=1 gives 32 cells by 7 lines. `cell_addr` = text line index (0-based) x cells per line + cell index (0-based), so the addresses run from 0x00 to 0xEF row by row.
- R3: Horizontal position counts from 0 at the clock edge that samples a rising `hsync`. The first active clock is at count max(`h_start`,16)+6, so a value of 0 to 15 behaves like 16.
- R4: A rising edge of `hsync` restarts horizontal counting at once, and `active` is 0 in the following cycle.
- R5: Scan lines are counted from 0 at the edge that samples a rising `vsync`, and each later `hsync` rising edge adds one. The first displayed scan line is number max(`v_start`,7), so a value of 0 to 6 behaves like 7. A rising `vsync` ends any display in progress.
- R6: The 2-bit size codes 0, 1, 2 and 3 select 1, 2, 3 and 4 clocks per dot horizontally, or 1, 2, 3 and 4 scan lines per dot vertically.
- R7: Text line 1 uses `hsize_top`/`vsize_top`. All other text lines and the gaps use `hsize_rest`/`vsize_rest`.
- R8: With `gap_en`=1, a blank band 18 x (vertical rest size) scan lines tall follows text line 2 and, in the 10-line mode, text line 8. `active` is 0 throughout the band.
- R9: `cursor_hit` is 1 only while `active` is 1, `cell_addr` equals `cursor_addr`, `cursor_addr` is not 0xFF, and `dot_row` is 16 (`cursor_low`=0) or 17 (`cursor_low`=1).
- R10: `active` is 0 outside the window, and `cell_addr` then holds the value it had in the last active cycle (0 after reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync | input | 1 | Horizontal sync, rising edge used |
| vsync | input | 1 | Vertical sync, rising edge used |
| h_start | input | 8 | Horizontal offset setting |
| v_start | input | 8 | Vertical offset setting |
| mode32 | input | 1 | Grid select: 0 = 24x10, 1 = 32x7 |
| gap_en | input | 1 | Insert blank bands below lines 2 and 8 |
| hsize_top | input | 2 | Horizontal size code, text line 1 |
| vsize_top | input | 2 | Vertical size code, text line 1 |
| hsize_rest | input | 2 | Horizontal size code, other lines |
| vsize_rest | input | 2 | Vertical size code, other lines and gaps |
| cursor_addr | input | 8 | Cursor cell, 0xFF = none |
| cursor_low | input | 1 | Underline on dot row 17 instead of 16 |
| active | output | 1 | Beam is inside a displayed cell |
| cell_addr | output | 8 | Display memory address of current cell |
| dot_col | output | 4 | Dot column in the glyph |
| dot_row | output | 5 | Dot row in the glyph |
| cursor_hit | output | 1 | Cursor underline dot is being drawn |

## Verification
A wrong horizontal sub-count shows up at once as a shifted `dot_col` or `cell_addr` within the same scan line. It also moves the right edge of the window, where `active` falls one or more clocks early or late. A wrong vertical state, such as a missed gap or a size code applied to the wrong text line, stays hidden until the affected band is scanned. From then on every later text line carries a wrong `cell_addr` or `dot_row`. The bench therefore probes scan lines both before and after each gap, and after an enlarged top line.

// File: rtl/char_raster_timer.sv
module char_raster_timer #(
  parameter int HCW     = 12,
  parameter int VCW     = 10,
  parameter int AW      = 8,
  parameter int GLYPH_W = 12,
  parameter int GLYPH_H = 18,
  parameter int COLS_A  = 24,
  parameter int LINES_A = 10,
  parameter int COLS_B  = 32,
  parameter int LINES_B = 7,
  parameter int HMIN    = 16,
  parameter int HBIAS   = 6,
  parameter int VMIN    = 7,
  localparam int DCW = $clog2(GLYPH_W),
  localparam int RCW = $clog2(GLYPH_H),
  localparam int CCW = $clog2(COLS_B + 1),
  localparam int LCW = $clog2(LINES_A + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hsync,
  input  logic           vsync,
  input  logic [AW-1:0]  h_start,
  input  logic [AW-1:0]  v_start,
  input  logic           mode32,
  input  logic           gap_en,
  input  logic [1:0]     hsize_top,
  input  logic [1:0]     vsize_top,
  input  logic [1:0]     hsize_rest,
  input  logic [1:0]     vsize_rest,
  input  logic [AW-1:0]  cursor_addr,
  input  logic           cursor_low,
  output logic           active,
  output logic [AW-1:0]  cell_addr,
  output logic [DCW-1:0] dot_col,
  output logic [RCW-1:0] dot_row,
  output logic           cursor_hit
);
  localparam int GAP1 = 1;
  localparam int GAP2 = 7;

  logic hs_q, vs_q, hs_rise, vs_rise;
  logic [HCW-1:0] hcnt, hbeg;
  logic [VCW-1:0] vcnt, vbeg;
  logic [AW-1:0]  hp_eff, vp_eff, live_addr, addr_hold;
  logic [1:0]     hsub, vsub, hcode, vcode;
  logic [DCW-1:0] hdot;
  logic [RCW-1:0] vdot;
  logic [CCW-1:0] hchar, ncols;
  logic [LCW-1:0] vline, nlines;
  logic           vgap, top_line, h_in, v_in;

  assign hs_rise  = hsync & ~hs_q;
  assign vs_rise  = vsync & ~vs_q;
  assign hp_eff   = (h_start < AW'(HMIN)) ? AW'(HMIN) : h_start;
  assign vp_eff   = (v_start < AW'(VMIN)) ? AW'(VMIN) : v_start;
  assign hbeg     = HCW'(hp_eff) + HCW'(HBIAS);
  assign vbeg     = VCW'(vp_eff);
  assign ncols    = mode32 ? CCW'(COLS_B) : CCW'(COLS_A);
  assign nlines   = mode32 ? LCW'(LINES_B) : LCW'(LINES_A);
  assign top_line = (vline == '0) && !vgap;
  assign hcode    = top_line ? hsize_top : hsize_rest;
  assign vcode    = top_line ? vsize_top : vsize_rest;

  assign h_in = (hcnt >= hbeg) && (hchar < ncols);
  assign v_in = (vcnt >= vbeg) && (vline < nlines);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q <= 1'b0;
      vs_q <= 1'b0;
    end else begin
      hs_q <= hsync;
      vs_q <= vsync;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt  <= '0;
      hsub  <= '0;
      hdot  <= '0;
      hchar <= '1;
    end else if (hs_rise) begin
      hcnt  <= '0;
      hsub  <= '0;
      hdot  <= '0;
      hchar <= '0;
    end else begin
      if (hcnt != '1) hcnt <= hcnt + 1'b1;
      if (h_in) begin
        if (hsub == hcode) begin
          hsub <= '0;
          if (hdot == DCW'(GLYPH_W - 1)) begin
            hdot  <= '0;
            hchar <= hchar + 1'b1;
          end else begin
            hdot <= hdot + 1'b1;
          end
        end else begin
          hsub <= hsub + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vcnt  <= '0;
      vsub  <= '0;
      vdot  <= '0;
      vline <= '1;
      vgap  <= 1'b0;
    end else if (vs_rise) begin
      vcnt  <= '0;
      vsub  <= '0;
      vdot  <= '0;
      vline <= '0;
      vgap  <= 1'b0;
    end else if (hs_rise) begin
      if (vcnt != '1) vcnt <= vcnt + 1'b1;
      if (v_in) begin
        if (vsub == vcode) begin
          vsub <= '0;
          if (vdot == RCW'(GLYPH_H - 1)) begin
            vdot <= '0;
            if (!vgap && gap_en && (vline == LCW'(GAP1) || vline == LCW'(GAP2))) begin
              vgap <= 1'b1;
            end else begin
              vgap  <= 1'b0;
              vline <= vline + 1'b1;
            end
          end else begin
            vdot <= vdot + 1'b1;
          end
        end else begin
          vsub <= vsub + 1'b1;
        end
      end
    end
  end

  assign active    = h_in && v_in && !vgap;
  assign live_addr = AW'(vline) * AW'(ncols) + AW'(hchar);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_hold <= '0;
    else if (active) addr_hold <= live_addr;
  end

  assign cell_addr  = active ? live_addr : addr_hold;
  assign dot_col    = hdot;
  assign dot_row    = vdot;
  assign cursor_hit = active && (cursor_addr != '1) && (live_addr == cursor_addr)
                      && (vdot == (cursor_low ? RCW'(GLYPH_H - 1) : RCW'(GLYPH_H - 2)));
endmodule

// File: rtl/char_raster_timer_chk.sv
module char_raster_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hsync,
  input logic       vsync,
  input logic       mode32,
  input logic [7:0] cursor_addr,
  input logic       active,
  input logic [7:0] cell_addr,
  input logic [3:0] dot_col,
  input logic [4:0] dot_row,
  input logic       cursor_hit
);
  AST_DOT_IN_GLYPH: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (dot_col < 4'd12) && (dot_row < 5'd18)); // R1

  AST_ADDR_IN_GRID: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> cell_addr <= (mode32 ? 8'd223 : 8'd239)); // R2

  AST_HSYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hsync) |=> !active); // R4

  AST_VSYNC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vsync) |=> !active); // R5

  AST_CURSOR_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    cursor_hit |-> active && (cell_addr == cursor_addr) && (cursor_addr != 8'hFF)
                   && (dot_row >= 5'd16)); // R9

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> cell_addr == $past(cell_addr)); // R10
endmodule

bind char_raster_timer char_raster_timer_chk u_chk (.*);

// File: tb/char_raster_timer_tb.sv
module char_raster_timer_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0]  hp;
    logic [7:0]  vp;
    logic        m32;
    logic        sp;
    logic [1:0]  hf;
    logic [1:0]  vf;
    logic [1:0]  hr;
    logic [1:0]  vr;
    logic [7:0]  cur;
    logic        c18;
    logic [9:0]  ln;
    logic [11:0] pos;
    logic        act;
  } vec_t;

  localparam int NV = 34;
  localparam vec_t TBL [NV] = '{
    '{8'd20, 8'd10, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 8'hFF, 1'b0, 10'd10,  12'd26,   1'b1}, // R3 R5 first cell
    '{8'd20, 8'd10, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 8'hFF, 1'b0, 10'd9,   12'd26,   1'b0}, // R5 line before
    '{8'd20, 8'd10, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 8'hFF, 1'b0, 10'd10,  12'd25,   1'b0}, // R3 clock before
    '{8'd20, 8'd10, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 8'hFF, 1'b0, 10'd27,  12'd313,  1'b1}, // R1 last dot
    '{8'd20, 8'd10, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 8'hFF, 1'b0, 10'd10,  12'd314,  1'b0}, // R10 right edge
    '{8'd20, 8'd10, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 8'hFF, 1'b0, 10'd28,  12'd38,   1'b1}, // R2 line 2
    '{8'd20, 8'd10, 1'b1, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 8'hFF, 1'b0, 10'd123, 12'd405,  1'b1}, // R2 32-col last line
    '{8'd20, 8'd10, 1'b1, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 8'hFF, 1'b0, 10'd136, 12'd26,   1'b0}, // R2 below 7 lines
    '{8'd20, 8'd10, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 8'hFF, 1'b0, 10'd189, 12'd302,  1'b1}, // R2 address 0xEF area
    '{8'd20, 8'd10, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 8'hFF, 1'b0, 10'd190, 12'd26,   1'b0}, // R10 below grid
    '{8'd3,  8'd0,  1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 8'hFF, 1'b0, 10'd7,   12'd22,   1'b1}, // R3 R5 clamp
    '{8'd3,  8'd0,  1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 8'hFF, 1'b0, 10'd6,   12'd22,   1'b0}, // R5 clamp
    '{8'd15, 8'd6,  1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 8'hFF, 1'b0, 10'd7,   12'd21,   1'b0}, // R3 clamp edge
    '{8'd16, 8'd7,  1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 8'hFF, 1'b0, 10'd7,   12'd22,   1'b1}, // R3 R5 minimum legal
    '{8'd20, 8'd10, 1'b0, 1'b0, 2'd2, 2'd3, 2'd0, 2'd0, 8'hFF, 1'b0, 10'd32,  12'd111,  1'b1}, // R6 R7 top enlarged
    '{8'd20, 8'd10, 1'b0, 1'b0, 2'd2, 2'd3, 2'd0, 2'd0, 8'hFF, 1'b0, 10'd82,  12'd38,   1'b1}, // R7 line 2 normal
    '{8'd20, 8'd10, 1'b0, 1'b0, 2'd2, 2'd3, 2'd0, 2'd0, 8'hFF, 1'b0, 10'd81,  12'd889,  1'b1}, // R6 top last dot
    '{8'd20, 8'd10, 1'b0, 1'b0, 2'd2, 2'd3, 2'd0, 2'd0, 8'hFF, 1'b0, 10'd81,  12'd890,  1'b0}, // R6 top right edge
    '{8'd20, 8'd10, 1'b0, 1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 8'hFF, 1'b0, 10'd46,  12'd26,   1'b0}, // R8 gap 1 start
    '{8'd20, 8'd10, 1'b0, 1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 8'hFF, 1'b0, 10'd63,  12'd26,   1'b0}, // R8 gap 1 end
    '{8'd20, 8'd10, 1'b0, 1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 8'hFF, 1'b0, 10'd64,  12'd26,   1'b1}, // R8 line 3
    '{8'd20, 8'd10, 1'b0, 1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 8'hFF, 1'b0, 10'd172, 12'd26,   1'b0}, // R8 gap 2
    '{8'd20, 8'd10, 1'b0, 1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 8'hFF, 1'b0, 10'd190, 12'd26,   1'b1}, // R8 line 9
    '{8'd20, 8'd10, 1'b1, 1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 8'hFF, 1'b0, 10'd153, 12'd26,   1'b1}, // R8 32-col last row
    '{8'd20, 8'd10, 1'b1, 1'b1, 2'd0, 2'd0, 2'd0, 2'd0, 8'hFF, 1'b0, 10'd154, 12'd26,   1'b0}, // R8 32-col end
    '{8'd20, 8'd10, 1'b0, 1'b1, 2'd0, 2'd0, 2'd0, 2'd1, 8'hFF, 1'b0, 10'd99,  12'd26,   1'b0}, // R8 tall gap
    '{8'd20, 8'd10, 1'b0, 1'b1, 2'd0, 2'd0, 2'd0, 2'd1, 8'hFF, 1'b0, 10'd100, 12'd26,   1'b1}, // R8 after tall gap
    '{8'd20, 8'd10, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 8'd25,  1'b0, 10'd44,  12'd38,   1'b1}, // R9 row 16 hit
    '{8'd20, 8'd10, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 8'd25,  1'b1, 10'd44,  12'd38,   1'b1}, // R9 row 16 miss
    '{8'd20, 8'd10, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 8'd25,  1'b1, 10'd45,  12'd38,   1'b1}, // R9 row 17 hit
    '{8'd20, 8'd10, 1'b0, 1'b0, 2'd0, 2'd0, 2'd0, 2'd0, 8'd25,  1'b0, 10'd44,  12'd26,   1'b1}, // R9 other cell
    '{8'd20, 8'd10, 1'b0, 1'b0, 2'd0, 2'd0, 2'd1, 2'd0, 8'hFF, 1'b0, 10'd28,  12'd103,  1'b1}, // R6 2 clocks/dot
    '{8'd20, 8'd10, 1'b0, 1'b0, 2'd0, 2'd0, 2'd3, 2'd0, 8'hFF, 1'b0, 10'd28,  12'd1178, 1'b0}, // R6 4x right edge
    '{8'd20, 8'd10, 1'b0, 1'b0, 2'd0, 2'd0, 2'd3, 2'd0, 8'hFF, 1'b0, 10'd28,  12'd1177, 1'b1}  // R6 4x last dot
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hsync = 1'b0, vsync = 1'b0;
  logic [7:0] h_start = 8'd20, v_start = 8'd10, cursor_addr = 8'hFF;
  logic       mode32 = 1'b0, gap_en = 1'b0, cursor_low = 1'b0;
  logic [1:0] hsize_top = 2'd0, vsize_top = 2'd0, hsize_rest = 2'd0, vsize_rest = 2'd0;
  logic       active, cursor_hit;
  logic [7:0] cell_addr;
  logic [3:0] dot_col;
  logic [4:0] dot_row;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  char_raster_timer u_dut (
    .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
    .h_start(h_start), .v_start(v_start), .mode32(mode32), .gap_en(gap_en),
    .hsize_top(hsize_top), .vsize_top(vsize_top),
    .hsize_rest(hsize_rest), .vsize_rest(vsize_rest),
    .cursor_addr(cursor_addr), .cursor_low(cursor_low),
    .active(active), .cell_addr(cell_addr), .dot_col(dot_col),
    .dot_row(dot_row), .cursor_hit(cursor_hit)
  );

  task automatic chk(string what, int got, int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %0d expected %0d", what, got, exp);
    end
  endtask

  function automatic void model(input vec_t v, output bit act, output int addr,
                                output int row, output int col);
    int hb, vb, nc, nl, m, line, hm, vm, p, c;
    act = 0; addr = 0; row = 0; col = 0;
    hb = ((v.hp < 16) ? 16 : int'(v.hp)) + 6;
    vb = (v.vp < 7) ? 7 : int'(v.vp);
    nc = v.m32 ? 32 : 24;
    nl = v.m32 ? 7 : 10;
    if (int'(v.ln) < vb || int'(v.pos) < hb) return;
    m = int'(v.ln) - vb;
    line = -1;
    for (int i = 0; i < nl; i++) begin
      vm = ((i == 0) ? int'(v.vf) : int'(v.vr)) + 1;
      if (m < 18 * vm) begin
        line = i;
        row = m / vm;
        break;
      end
      m -= 18 * vm;
      if (v.sp && (i == 1 || i == 7) && i < nl - 1) begin
        if (m < 18 * (int'(v.vr) + 1)) return;
        m -= 18 * (int'(v.vr) + 1);
      end
    end
    if (line < 0) return;
    hm = ((line == 0) ? int'(v.hf) : int'(v.hr)) + 1;
    p = int'(v.pos) - hb;
    c = p / (12 * hm);
    if (c >= nc) return;
    col = (p / hm) % 12;
    addr = line * nc + c;
    act = 1;
  endfunction

  task automatic probe(int ln, int pos);
    @(negedge clk); vsync = 1'b1; hsync = 1'b1;
    @(negedge clk); vsync = 1'b0; hsync = 1'b0;
    for (int i = 0; i < ln; i++) begin
      @(negedge clk); hsync = 1'b1;
      @(negedge clk); hsync = 1'b0;
    end
    repeat (pos) @(negedge clk);
  endtask

  task automatic apply(vec_t v);
    h_start = v.hp; v_start = v.vp; mode32 = v.m32; gap_en = v.sp;
    hsize_top = v.hf; vsize_top = v.vf; hsize_rest = v.hr; vsize_rest = v.vr;
    cursor_addr = v.cur; cursor_low = v.c18;
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL watchdog expired got 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    bit e_act;
    int e_addr, e_row, e_col, e_hit;
    repeat (3) @(negedge clk);
    // reset state: R10
    chk("R10 reset active", int'(active), 0);
    chk("R10 reset cell_addr", int'(cell_addr), 0);
    chk("R9 reset cursor_hit", int'(cursor_hit), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 idle after reset active", int'(active), 0);

    for (int k = 0; k < NV; k++) begin
      apply(TBL[k]);
      probe(int'(TBL[k].ln), int'(TBL[k].pos));
      model(TBL[k], e_act, e_addr, e_row, e_col);
      e_hit = (TBL[k].act && TBL[k].cur != 8'hFF && e_addr == int'(TBL[k].cur)
               && e_row == (TBL[k].c18 ? 17 : 16)) ? 1 : 0;
      chk($sformatf("R3 R5 R6 R7 R8 R10 active vec %0d", k), int'(active), int'(TBL[k].act));
      if (TBL[k].act) begin
        chk($sformatf("R2 R7 address vec %0d", k), int'(cell_addr), e_addr);
        chk($sformatf("R1 R6 dot_row vec %0d", k), int'(dot_row), e_row);
        chk($sformatf("R1 R6 dot_col vec %0d", k), int'(dot_col), e_col);
      end
      chk($sformatf("R9 cursor vec %0d", k), int'(cursor_hit), e_hit);
    end

    // R10: address holds after the right edge of the window
    apply(TBL[0]);
    probe(27, 313);
    chk("R10 last cell before edge", int'(cell_addr), 23);
    @(negedge clk);
    chk("R10 active past edge", int'(active), 0);
    chk("R10 held address", int'(cell_addr), 23);
    repeat (40) @(negedge clk);
    chk("R10 held address later", int'(cell_addr), 23);

    // R4: hsync mid-window restarts the horizontal count
    probe(10, 30);
    chk("R4 active before restart", int'(active), 1);
    @(negedge clk); hsync = 1'b1;
    @(negedge clk); hsync = 1'b0;
    chk("R4 inactive after hsync rise", int'(active), 0);
    repeat (26) @(negedge clk);
    chk("R4 active again at start", int'(active), 1);
    chk("R4 col restarts", int'(dot_col), 0);
    chk("R4 row advanced", int'(dot_row), 1);

    // R5: vsync mid-window ends display
    probe(12, 40);
    chk("R5 active before vsync", int'(active), 1);
    @(negedge clk); vsync = 1'b1;
    @(negedge clk); vsync = 1'b0;
    repeat (30) @(negedge clk);
    chk("R5 inactive after vsync", int'(active), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule